// File: doc/BRIEF.md
# Table-Coded Clock Divider with Stop Control

This block derives a divided clock-enable from its input clock. Software writes one control word that carries two things: a 4-bit ratio code and an active-high stop flag. The code indexes a fixed, sparse table of divisors. Most of these divisors are not powers of two, and some codes are left unused. When the stop flag is clear, the output gives a single-cycle enable pulse once every N input cycles, where N is the divisor that the code selects.

A write that carries an unused code changes only the stop flag. The divisor and the stored code stay as they were. A new divisor is taken up at the next wrap of the division counter, so no period is ever shortened. Setting the stop flag silences the output from the next cycle. Clearing it again starts the count afresh from zero. The control word can be read back at any time.

A parameter chooses one of three table variants. The base table is the default. A second variant also accepts code 0, and a third drops the three smallest ratios and adds one more.

Top module: `tdiv_gate`

## Requirements
- R1: After reset the output enable is low, the stop flag reads 1, and the code field holds the first valid entry of the selected table: 1 for the base table, 0 for variant 1, and 4 for variant 2.
- R2: In the base table, codes 1, 2, 3, 4, 5, 6, 7 and 8 give periods of 3, 4, 6, 8, 12, 16, 18 and 24 input cycles.
- R3: In the base table, code 11 gives a period of 48 cycles and code 10 gives a period of 36 cycles.
- R4: A write with an unused code (base table: 0, 9, 12 to 15) leaves both the stored code and the active divisor unchanged, while the stop flag is still taken from the write.
- R5: When the stop flag (control bit 8) is 1, the enable output is low from the cycle after it is set and stays low. When the flag is 0, the output runs.
- R6: While running with divisor N, the enable is high for exactly one cycle in every N. After a write that clears the stop flag, the first pulse follows exactly N clock edges after the write edge, because the counter restarts from zero.
- R7: A code change made while running completes the current period with the old divisor. The new divisor governs every period after that.
- R8: The readback holds the stop flag at bit 8 and the stored code at bits 3:0. Bits 7:4 always read 0, whatever was written to them.
- R9: Variant 1 (TABLE_SEL=1) maps code 0 to a period of 2. Variant 2 (TABLE_SEL=2) maps code 12 to a period of 10 and treats codes 0 to 3 as unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | STOP_BIT+1 | Control word: code at [3:0], stop flag at [STOP_BIT] |
| clk_en_o | output | 1 | Registered divided clock-enable pulse |
| ctrl_rd | output | STOP_BIT+1 | Readback of the stored control word |

## Verification
The base-table instance is swept over all sixteen codes. Each code is first written with the stop flag set and the reserved bits filled with ones, then written again with the flag cleared. This pattern separates valid codes, whose exact period and first-pulse position are measured, from unused codes, which must reproduce the period of the previous valid code. A mid-period code change from 12 to 3 shows whether the new ratio waits for the wrap. A stop in mid-count followed by a restart shows whether the counter begins again from zero. Two variant instances receive the same writes, which shows that codes 0 and 12 are decoded differently per table.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 6;

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] div;
  } tdiv_ent_t;

  // Divisor table; sel picks the variant (0 base, 1 adds code 0, 2 sparse high set)
  function automatic tdiv_ent_t tdiv_lookup(input int sel, input logic [CODE_W-1:0] code);
    tdiv_ent_t e;
    e = '0;
    case (code)
      4'd0:  if (sel == 1) e = '{ok: 1'b1, div: DIV_W'(2)};
      4'd1:  if (sel != 2) e = '{ok: 1'b1, div: DIV_W'(3)};
      4'd2:  if (sel != 2) e = '{ok: 1'b1, div: DIV_W'(4)};
      4'd3:  if (sel != 2) e = '{ok: 1'b1, div: DIV_W'(6)};
      4'd4:  e = '{ok: 1'b1, div: DIV_W'(8)};
      4'd5:  e = '{ok: 1'b1, div: DIV_W'(12)};
      4'd6:  e = '{ok: 1'b1, div: DIV_W'(16)};
      4'd7:  e = '{ok: 1'b1, div: DIV_W'(18)};
      4'd8:  e = '{ok: 1'b1, div: DIV_W'(24)};
      4'd10: e = '{ok: 1'b1, div: DIV_W'(36)};
      4'd11: e = '{ok: 1'b1, div: DIV_W'(48)};
      4'd12: if (sel == 2) e = '{ok: 1'b1, div: DIV_W'(10)};
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [CODE_W-1:0] tdiv_first_code(input int sel);
    if (sel == 1) return CODE_W'(0);
    if (sel == 2) return CODE_W'(4);
    return CODE_W'(1);
  endfunction
endpackage

// File: rtl/tdiv_lut.sv
module tdiv_lut
  import tdiv_pkg::*;
#(
  parameter int TABLE_SEL = 0
) (
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  div
);
  tdiv_ent_t ent;

  always_comb begin
    ent = tdiv_lookup(TABLE_SEL, code);
    div = ent.div;
  end
endmodule

// File: rtl/tdiv_ctrl.sv
module tdiv_ctrl
  import tdiv_pkg::*;
#(
  parameter int TABLE_SEL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_stop,
  output logic              wr_ok,
  output logic [CODE_W-1:0] code_d,
  output logic [CODE_W-1:0] code_q,
  output logic              stop_q
);
  tdiv_ent_t wr_ent;

  always_comb begin
    wr_ent = tdiv_lookup(TABLE_SEL, wr_code);
    wr_ok  = wr_ent.ok;
    code_d = (wr_en && wr_ok) ? wr_code : code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= tdiv_first_code(TABLE_SEL);
      stop_q <= 1'b1;
    end else begin
      code_q <= code_d;
      if (wr_en) stop_q <= wr_stop;
    end
  end
endmodule

// File: rtl/tdiv_count.sv
module tdiv_count
  import tdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stop,
  input  logic [DIV_W-1:0] next_div,
  output logic             pulse_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] act_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;
  logic             wrap;

  assign wrap  = (cnt_q == act_q - DIV_W'(1));
  assign cnt_o = cnt_q;
  assign act_o = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_q   <= '1;
      pulse_o <= 1'b0;
    end else if (stop) begin
      cnt_q   <= '0;
      act_q   <= next_div;
      pulse_o <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      act_q   <= next_div;
      pulse_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + DIV_W'(1);
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tdiv_gate.sv
module tdiv_gate
  import tdiv_pkg::*;
#(
  parameter int TABLE_SEL = 0,
  parameter int STOP_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STOP_BIT:0] wr_data,
  output logic              clk_en_o,
  output logic [STOP_BIT:0] ctrl_rd
);
  localparam int RSV_W = STOP_BIT - CODE_W;

  logic              wr_ok;
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] code_q;
  logic              stop_q;
  logic [DIV_W-1:0]  next_div;
  logic [DIV_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  act_div_q;

  tdiv_ctrl #(.TABLE_SEL(TABLE_SEL)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_code (wr_data[CODE_W-1:0]),
    .wr_stop (wr_data[STOP_BIT]),
    .wr_ok   (wr_ok),
    .code_d  (code_d),
    .code_q  (code_q),
    .stop_q  (stop_q)
  );

  tdiv_lut #(.TABLE_SEL(TABLE_SEL)) u_lut (
    .code (code_d),
    .div  (next_div)
  );

  tdiv_count u_count (
    .clk      (clk),
    .rst      (rst),
    .stop     (stop_q),
    .next_div (next_div),
    .pulse_o  (clk_en_o),
    .cnt_o    (cnt_q),
    .act_o    (act_div_q)
  );

  assign ctrl_rd = {stop_q, {RSV_W{1'b0}}, code_q};
endmodule

// File: rtl/tdiv_gate_chk.sv
module tdiv_gate_chk
  import tdiv_pkg::*;
#(
  parameter int STOP_BIT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [STOP_BIT:0] wr_data,
  input logic              wr_ok,
  input logic              clk_en_o,
  input logic [STOP_BIT:0] ctrl_rd,
  input logic [DIV_W-1:0]  cnt,
  input logic [DIV_W-1:0]  act_div
);
  // R1: first cycle out of reset shows stopped, quiet output
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!clk_en_o && ctrl_rd[STOP_BIT]));

  // R4: unused code keeps the stored code
  a_r4_invalid_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ok) |=> $stable(ctrl_rd[CODE_W-1:0]));

  // R5: stop flag silences the output on the next cycle
  a_r5_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd[STOP_BIT] |=> !clk_en_o);

  // R6: pulses are a single cycle wide (smallest divisor is 2)
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    clk_en_o |=> !clk_en_o);

  // R6: counter stays below the active divisor while running
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rd[STOP_BIT] |-> (cnt < act_div));

  // R7: divisor changes only at a wrap or while stopped
  a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(act_div));

  // R8: reserved write bits never reach the readback
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data[STOP_BIT-1:CODE_W] != '0)) |=> (ctrl_rd[STOP_BIT-1:CODE_W] == '0));
endmodule

bind tdiv_gate tdiv_gate_chk #(.STOP_BIT(STOP_BIT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .wr_ok    (wr_ok),
  .clk_en_o (clk_en_o),
  .ctrl_rd  (ctrl_rd),
  .cnt      (cnt_q),
  .act_div  (act_div_q)
);

// File: tb/tdiv_gate_bench.sv
module tdiv_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [2:0] en;
  logic [8:0] rd0, rd1, rd2;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tdiv_gate #(.TABLE_SEL(0)) u_tdiv_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .clk_en_o(en[0]), .ctrl_rd(rd0));
  tdiv_gate #(.TABLE_SEL(1)) u_tdiv_gate_v1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .clk_en_o(en[1]), .ctrl_rd(rd1));
  tdiv_gate #(.TABLE_SEL(2)) u_tdiv_gate_v2 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .clk_en_o(en[2]), .ctrl_rd(rd2));

  // Specified periods of the base table; 0 marks an unused code
  function automatic int base_div(input int code);
    case (code)
      1: return 3;   2: return 4;   3: return 6;   4: return 8;
      5: return 12;  6: return 16;  7: return 18;  8: return 24;
      10: return 36; 11: return 48;
      default: return 0;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [8:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulses expected exactly at edges d and 2d after the write edge
  task automatic expect_period(input int w, input int d, input string req);
    int bad = -1;
    for (int k = 1; k <= 2 * d; k++) begin
      tick();
      if (bad < 0 && en[w] !== ((k == d) || (k == 2 * d))) bad = k;
    end
    chk(bad < 0, req, $sformatf("pulse pattern for period %0d, first wrong cycle", d), bad, -1);
  endtask

  task automatic wait_pulse(input int w);
    int g = 0;
    do begin
      tick();
      g++;
    end while (!en[w] && g < 500);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cur;
    int bad;
    string req;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk(rd0 == 9'h101, "R1", "base readback", rd0, 9'h101);
    chk(rd1 == 9'h100, "R1", "variant 1 readback", rd1, 9'h100);
    chk(rd2 == 9'h104, "R1", "variant 2 readback", rd2, 9'h104);
    chk(en == 3'b000, "R1", "enables low", en, 0);
    repeat (5) tick();
    chk(en == 3'b000, "R1", "enables stay low while stopped", en, 0);

    // Sweep all codes of the base table; reserved bits 7:4 written as ones
    cur = 1;
    for (int code = 0; code < 16; code++) begin
      if (base_div(code) > 0) begin
        cur = code;
        req = (code >= 10) ? "R3" : "R2";
      end else begin
        req = "R4";
      end
      wr({1'b1, 4'hF, 4'(code)});
      chk(rd0 == (9'h100 | 9'(cur)), req, $sformatf("readback after code %0d (R8 layout)", code),
          rd0, 9'h100 | cur);
      chk(rd0[7:4] == 4'h0, "R8", "reserved bits", rd0[7:4], 0);
      wr({1'b0, 4'hF, 4'(code)});
      chk(rd0[8] == 1'b0, "R5", "stop flag cleared", rd0[8], 0);
      expect_period(0, base_div(cur), req);
    end

    // R7: change 12 -> 3 in mid period
    wr(9'h105);
    wr(9'h005);
    wait_pulse(0);
    tick();
    tick();
    wr(9'h001);
    bad = -1;
    for (int k = 1; k <= 15; k++) begin
      tick();
      if (bad < 0 && en[0] !== ((k == 9) || (k == 12) || (k == 15))) bad = k;
    end
    chk(bad < 0, "R7", "old period completes before new ratio", bad, -1);

    // R5: stop silences output
    wr(9'h101);
    chk(rd0 == 9'h101, "R5", "readback with stop set", rd0, 9'h101);
    bad = -1;
    for (int k = 1; k <= 40; k++) begin
      tick();
      if (bad < 0 && en[0] !== 1'b0) bad = k;
    end
    chk(bad < 0, "R5", "output quiet while stopped", bad, -1);
    wr(9'h001);
    expect_period(0, 3, "R6");

    // R6: stop in mid count, restart counts from zero
    wr(9'h105);
    wr(9'h005);
    wait_pulse(0);
    repeat (4) tick();
    wr(9'h105);
    tick();
    wr(9'h005);
    expect_period(0, 12, "R6");

    // R4: unused code while stopped keeps code 5 and period 12
    wr(9'h109);
    chk(rd0 == 9'h105, "R4", "code kept on stopped write", rd0, 9'h105);
    wr(9'h009);
    chk(rd0 == 9'h005, "R4", "code kept, stop taken", rd0, 9'h005);
    expect_period(0, 12, "R4");

    // R9: variant tables
    wr(9'h10C);
    wr(9'h00C);
    chk(rd2 == 9'h00C, "R9", "variant 2 accepts code 12", rd2, 9'h00C);
    chk(rd0 == 9'h005, "R9", "base ignores code 12", rd0, 9'h005);
    expect_period(2, 10, "R9");
    wr(9'h100);
    chk(rd1 == 9'h100, "R9", "variant 1 accepts code 0", rd1, 9'h100);
    chk(rd2 == 9'h10C, "R9", "variant 2 ignores code 0", rd2, 9'h10C);
    wr(9'h000);
    expect_period(1, 2, "R9");
    wr(9'h101);
    chk(rd2 == 9'h10C, "R9", "variant 2 ignores code 1", rd2, 9'h10C);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule